// File: doc/BRIEF.md
# Timed Access Unlock Controller

This block protects a set of critical control fields (watchdog settings, wait-state settings, the power-fail reset flag) from accidental writes by runaway code. Software must write a two-byte key into a dedicated key register, first 0xAA and then 0x55, and the second write must belong to the instruction that directly follows the first. A correct key opens a short unlock window whose length is counted in machine cycles, not raw clocks. While the window is open the block raises an unlock enable, which the guarded registers use to accept writes.

The block also gates one protected-write request. A request made while the window is open is granted. A request made at any other time is refused. Any instruction that completes between the two key writes breaks the sequence. A wrong second byte returns the controller to the locked state. The guarded registers themselves live outside this block.

Top module: `ta_unlock_ctrl`

## Requirements
- R1: After reset, unlock_en and prot_ok are 0 and no first key byte is pending.
- R2: A key write of 0xAA, followed by a key write of 0x55 with no instruction step pulse between them, raises unlock_en on the clock edge that captures the 0x55 write, so it is visible in the following cycle.
- R3: Once opened, unlock_en stays high until exactly WINDOW_MC (default 3) mc_tick pulses have been captured after the opening edge, and falls on the edge that captures the last of them; clocks without a tick never close it.
- R4: prot_ok equals prot_wr while unlock_en is high and is 0 otherwise, so a protected write after the window has closed is refused.
- R5: An insn_step pulse (with key_wr low) while the 0xAA byte is pending discards it, and a later 0x55 write opens no window.
- R6: A key write of any value other than 0x55 or 0xAA while the 0xAA byte is pending discards it, and a later 0x55 write opens no window.
- R7: A key write of 0xAA while the 0xAA byte is already pending keeps it pending, so a directly following 0x55 write still opens the window.
- R8: A key write of 0x55 with no pending 0xAA byte opens no window.
- R9: Protected writes during an open window do not shorten it; the window closes only on tick expiry.
- R10: A complete key sequence finished while the window is open restarts the window at its full length of WINDOW_MC ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_wr | input | 1 | Write strobe for the key register, one cycle per write |
| key_data | input | 8 | Data written to the key register |
| insn_step | input | 1 | Pulse when an instruction completes without writing the key register |
| mc_tick | input | 1 | One-cycle pulse per machine cycle |
| prot_wr | input | 1 | Protected-field write request |
| unlock_en | output | 1 | Unlock enable for the guarded fields |
| prot_ok | output | 1 | Protected write granted in this cycle |

## Verification
The assertions assume that mc_tick, key_wr and insn_step are single-cycle qualifiers sampled on the rising edge. They also assume that insn_step never arrives in the same cycle as a key write, because the instruction that writes the key does not also report a step. The abort property is written under that exclusivity. The random stimulus draws insn_step only in cycles where key_wr is low, and it biases the key data toward 0xAA and 0x55 so that the arm, abort and reload paths all occur often.

// File: rtl/ta_pkg.sv
package ta_pkg;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;

  typedef enum logic [0:0] {
    SEQ_IDLE  = 1'b0,
    SEQ_ARMED = 1'b1
  } seq_state_t;

  typedef struct packed {
    seq_state_t nxt;
    logic       hit;
    logic       abort;
  } seq_step_t;

  // Key sequencer transition: a key write always wins over an instruction step.
  function automatic seq_step_t seq_advance(input seq_state_t cur,
                                            input logic wr,
                                            input logic [7:0] data,
                                            input logic step);
    seq_step_t r;
    r.nxt   = cur;
    r.hit   = 1'b0;
    r.abort = 1'b0;
    if (wr) begin
      if (data == KEY_FIRST) begin
        r.nxt = SEQ_ARMED;
      end else if (cur == SEQ_ARMED && data == KEY_SECOND) begin
        r.nxt = SEQ_IDLE;
        r.hit = 1'b1;
      end else begin
        r.abort = (cur == SEQ_ARMED);
        r.nxt   = SEQ_IDLE;
      end
    end else if (step && cur == SEQ_ARMED) begin
      r.nxt   = SEQ_IDLE;
      r.abort = 1'b1;
    end
    return r;
  endfunction

  // Window countdown: reload on a key hit, otherwise one step down per tick.
  function automatic int unsigned win_advance(input int unsigned cur,
                                              input logic hit,
                                              input logic tick,
                                              input int unsigned full);
    if (hit)
      return full;
    else if (tick && cur != 0)
      return cur - 1;
    else
      return cur;
  endfunction

endpackage

// File: rtl/ta_key_seq.sv
module ta_key_seq
  import ta_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_data,
  input  logic       insn_step,
  output logic       armed,
  output logic       hit,
  output logic       abort
);

  seq_state_t state_q;
  seq_step_t  step_w;

  always_comb begin
    step_w = seq_advance(state_q, key_wr, key_data, insn_step);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state_q <= SEQ_IDLE;
    else
      state_q <= step_w.nxt;
  end

  assign armed = (state_q == SEQ_ARMED);
  assign hit   = step_w.hit;
  assign abort = step_w.abort;

endmodule

// File: rtl/ta_window.sv
module ta_window
  import ta_pkg::*;
#(
  parameter int unsigned WINDOW_MC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic mc_tick,
  output logic open,
  output logic expire
);

  localparam int unsigned CW = $clog2(WINDOW_MC + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = CW'(win_advance(int'(cnt_q), hit, mc_tick, WINDOW_MC));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign open   = (cnt_q != '0);
  assign expire = open && (cnt_d == '0);

endmodule

// File: rtl/ta_unlock_ctrl.sv
module ta_unlock_ctrl #(
  parameter int unsigned WINDOW_MC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_data,
  input  logic       insn_step,
  input  logic       mc_tick,
  input  logic       prot_wr,
  output logic       unlock_en,
  output logic       prot_ok
);

  logic seq_armed;
  logic seq_hit;
  logic seq_abort;
  logic win_open;
  logic win_expire;

  ta_key_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_data (key_data),
    .insn_step(insn_step),
    .armed    (seq_armed),
    .hit      (seq_hit),
    .abort    (seq_abort)
  );

  ta_window #(.WINDOW_MC(WINDOW_MC)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (seq_hit),
    .mc_tick(mc_tick),
    .open   (win_open),
    .expire (win_expire)
  );

  assign unlock_en = win_open;
  assign prot_ok   = prot_wr & win_open;

endmodule

// File: rtl/ta_unlock_chk.sv
module ta_unlock_chk #(
  parameter int unsigned WINDOW_MC = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       key_wr,
  input logic       insn_step,
  input logic       mc_tick,
  input logic       prot_wr,
  input logic       unlock_en,
  input logic       prot_ok,
  input logic       seq_armed,
  input logic       seq_hit,
  input logic       win_expire
);

  int unsigned ticks_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ticks_seen <= 0;
    else if (seq_hit)
      ticks_seen <= 0;
    else if (unlock_en && mc_tick)
      ticks_seen <= ticks_seen + 1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |-> !unlock_en && !prot_ok);

  // R2
  open_after_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_hit |=> unlock_en);

  // R3
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_en && !mc_tick |=> unlock_en);

  // R3
  close_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(unlock_en) |-> $past(mc_tick) && !$past(seq_hit));

  // R3
  window_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_en |-> ticks_seen < WINDOW_MC);

  // R4
  grant_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_ok == (prot_wr && unlock_en));

  // R5
  step_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_armed && insn_step && !key_wr |=> !seq_armed);

  // R8
  open_only_by_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlock_en) |-> $past(seq_hit));

  // R9
  expire_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_expire |-> mc_tick && !seq_hit);

endmodule

bind ta_unlock_ctrl ta_unlock_chk #(.WINDOW_MC(WINDOW_MC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .key_wr    (key_wr),
  .insn_step (insn_step),
  .mc_tick   (mc_tick),
  .prot_wr   (prot_wr),
  .unlock_en (unlock_en),
  .prot_ok   (prot_ok),
  .seq_armed (seq_armed),
  .seq_hit   (seq_hit),
  .win_expire(win_expire)
);

// File: tb/ta_unlock_ctrl_tb.sv
module ta_unlock_ctrl_tb;

  localparam int WIN = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       key_wr = 1'b0;
  logic [7:0] key_data = 8'h00;
  logic       insn_step = 1'b0;
  logic       mc_tick = 1'b0;
  logic       prot_wr = 1'b0;
  logic       unlock_en;
  logic       prot_ok;

  int n_cmp = 0;
  int n_bad = 0;

  // bench reference state
  bit m_pending = 0;
  int m_left = 0;

  always #5 clk = ~clk;

  ta_unlock_ctrl #(.WINDOW_MC(WIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(key_data),
    .insn_step(insn_step), .mc_tick(mc_tick), .prot_wr(prot_wr),
    .unlock_en(unlock_en), .prot_ok(prot_ok)
  );

  function automatic bit exp_grant(input bit req, input int left);
    return req && (left > 0);
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Apply one cycle of inputs, compare before the edge, then advance the reference.
  task automatic cyc(input string tag, input bit wr, input logic [7:0] d,
                     input bit step, input bit tick, input bit pw);
    bit done;
    key_wr = wr; key_data = d; insn_step = step; mc_tick = tick; prot_wr = pw;
    @(negedge clk);
    check(tag, "unlock_en", unlock_en, m_left > 0);
    check(tag, "prot_ok", prot_ok, exp_grant(pw, m_left));
    @(posedge clk);
    done = wr && m_pending && d == 8'h55;
    if (wr) m_pending = (d == 8'hAA);
    else if (step) m_pending = 0;
    if (done) m_left = WIN;
    else if (tick && m_left > 0) m_left = m_left - 1;
    #1;
  endtask

  task automatic idle(input string tag, input int n, input bit tick);
    for (int i = 0; i < n; i++) cyc(tag, 0, 8'h00, 0, tick, 0);
  endtask

  task automatic drain();
    idle("drain", WIN + 1, 1);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", "unlock_en in reset", unlock_en, 1'b0);
    check("R1", "prot_ok in reset", prot_ok, 1'b0);
    rst_n = 1'b1;
    idle("R1", 2, 1);
    cyc("R1", 1, 8'h55, 0, 0, 1);   // no pending byte after reset
    idle("R1", 1, 0);

    // R2 basic unlock, R3 exact length with gaps
    cyc("R2", 1, 8'hAA, 0, 0, 0);
    cyc("R2", 1, 8'h55, 0, 1, 0);   // tick on the opening edge is not counted
    idle("R3", 6, 0);               // no tick: stays open
    cyc("R3", 0, 8'h00, 0, 1, 0);
    idle("R3", 2, 0);
    cyc("R3", 0, 8'h00, 0, 1, 0);
    cyc("R3", 0, 8'h00, 0, 1, 0);   // closes here
    // R4 refused after expiry
    cyc("R4", 0, 8'h00, 0, 0, 1);
    cyc("R4", 0, 8'h00, 0, 1, 1);

    // R5 instruction between key bytes
    cyc("R5", 1, 8'hAA, 0, 0, 0);
    cyc("R5", 0, 8'h00, 1, 0, 0);
    cyc("R5", 1, 8'h55, 0, 0, 0);
    idle("R5", 2, 0);

    // R6 wrong second byte
    cyc("R6", 1, 8'hAA, 0, 0, 0);
    cyc("R6", 1, 8'h5A, 0, 0, 0);
    cyc("R6", 1, 8'h55, 0, 0, 0);
    idle("R6", 2, 0);

    // R7 repeated first byte
    cyc("R7", 1, 8'hAA, 0, 0, 0);
    cyc("R7", 1, 8'hAA, 0, 0, 0);
    cyc("R7", 1, 8'h55, 0, 0, 0);
    idle("R7", 1, 0);
    drain();

    // R8 second byte alone
    cyc("R8", 1, 8'h55, 0, 1, 0);
    cyc("R8", 1, 8'h55, 0, 0, 1);
    idle("R8", 1, 0);

    // R9 protected writes inside the window
    cyc("R9", 1, 8'hAA, 0, 0, 0);
    cyc("R9", 1, 8'h55, 0, 0, 0);
    for (int i = 0; i < 5; i++) cyc("R9", 0, 8'h00, 0, 0, 1);
    cyc("R9", 0, 8'h00, 0, 1, 1);
    cyc("R9", 0, 8'h00, 0, 1, 1);
    cyc("R9", 0, 8'h00, 0, 1, 1);
    cyc("R9", 0, 8'h00, 0, 0, 1);

    // R10 reload while open
    cyc("R10", 1, 8'hAA, 0, 0, 0);
    cyc("R10", 1, 8'h55, 0, 0, 0);
    cyc("R10", 0, 8'h00, 0, 1, 0);
    cyc("R10", 0, 8'h00, 0, 1, 0);
    cyc("R10", 1, 8'hAA, 0, 0, 0);
    cyc("R10", 1, 8'h55, 0, 1, 0);
    cyc("R10", 0, 8'h00, 0, 1, 0);
    cyc("R10", 0, 8'h00, 0, 1, 0);
    cyc("R10", 0, 8'h00, 0, 0, 1);   // still open: full reload
    cyc("R10", 0, 8'h00, 0, 1, 1);
    cyc("R10", 0, 8'h00, 0, 0, 1);

    // Random mix covering R2 R3 R4 R5 R6 R7
    for (int i = 0; i < 4000; i++) begin
      bit wr, st, tk, pw;
      logic [7:0] d;
      int sel;
      wr = ($urandom_range(0, 2) == 0);
      sel = $urandom_range(0, 9);
      d = (sel < 4) ? 8'hAA : (sel < 8) ? 8'h55 : 8'($urandom_range(0, 255));
      st = !wr && ($urandom_range(0, 3) == 0);
      tk = ($urandom_range(0, 3) == 0);
      pw = ($urandom_range(0, 1) == 0);
      cyc("R4 random", wr, d, st, tk, pw);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule